// File: doc/BRIEF.md
# Clock Controller Register Bank with Atomic Bit Aliases

This block holds the configuration words of a clock controller and exposes them on a simple word-addressed bus with separate write and read channels. Two of its registers, a fractional-divider word and a bypass-select word, have four addresses each. The first address replaces the word. The other three set, clear or toggle only the bits that are 1 in the write data, so software can change one gate or one bypass bit without a read-modify-write sequence. Five further per-peripheral clock words (serial port, memory interface, pixel, NAND interface, audio interface) accept only a plain write at their base address.

The fractional-divider word has four 6-bit divide fields, each with a gate bit at the top of its byte. The derived clock of a field is the PLL rate times 18 divided by the field value. The block keeps every field inside its legal range of 18 to 35: it clamps any result that would fall outside and records the attempt in a sticky error bit. The clock logic downstream reads the fractional word, the bypass bits and the error bit straight from the output ports.

Top module: `clkreg_bank`

## Requirements
- R1: After reset the fractional word reads 0x92929292 (every field 18, every gate bit 1), the bypass word reads 0x000001F0, the five plain words read 0 and the status word reads 0.
- R2: A write to the base offset (address bits 3:2 = 00) of an aliased register replaces its writable bits with the write data.
- R3: A write to base+4 (bits 3:2 = 01) of an aliased register ORs the write data into it.
- R4: A write to base+8 (bits 3:2 = 10) of an aliased register clears every bit that is 1 in the write data.
- R5: A write to base+12 (bits 3:2 = 11) of an aliased register inverts every bit that is 1 in the write data.
- R6: A read with rd_en high returns data, with rd_valid high, in the next cycle, and rd_valid is low in the cycle after a cycle without rd_en. A read of any of the four alias addresses returns the base register value. The fractional word is at 0x00 and the bypass word at 0x10.
- R7: The five plain words sit at 0x20, 0x30, 0x40, 0x50 and 0x60, store all 32 bits of a write to the base address, ignore writes to base+4, +8 and +12, and read as 0 at those three addresses.
- R8: The fractional fields sit at bits 5:0, 13:8, 21:16 and 29:24. After any write to the fractional word, a field whose result is below 18 is stored as 18 and one above 35 as 35.
- R9: A clamp sets a sticky error bit, read as bit 0 of the status word at 0x70 and driven on err_flag. Writes cannot clear it. Only reset clears it.
- R10: Addresses with nonzero bits 1:0, addresses at or above 0x80 and writes to the status word change no state, and reads of unmapped addresses return 0.
- R11: When a read and a write reach the same register in one cycle, the read returns the value held before the write.
- R12: Reserved bits always read 0: bits 30, 22, 14 and 6 of the fractional word and every bypass bit outside 8:4.
- R13: frac_cfg shows the fractional word and bypass_cfg shows bypass bits 8:4 (bit 4 in bypass_cfg[0]), both updated in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data or bit mask for alias writes |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| rd_valid | output | 1 | Marks rd_data as valid |
| frac_cfg | output | 32 | Current fractional-divider word |
| bypass_cfg | output | 5 | Current bypass-select bits |
| err_flag | output | 1 | Sticky out-of-range error |

## Verification
A read and a write can land in the same cycle because the two channels are independent. The bench provokes this by driving both strobes at one plain word. The scoreboard expects the old contents on that read, and a read in the following cycle must show the new value. The other overlap is an alias write whose result must be clamped: the register update and the error flag both change on the same edge. The bench checks both, and checks the error bit is still set after a later write to the status address.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

    // Alias operation; its encoding equals address bits 3:2
    typedef enum logic [1:0] {
        ALIAS_WR  = 2'd0,
        ALIAS_SET = 2'd1,
        ALIAS_CLR = 2'd2,
        ALIAS_TOG = 2'd3
    } alias_op_e;

    typedef enum logic [2:0] {
        REG_NONE  = 3'd0,
        REG_FRAC  = 3'd1,
        REG_BYP   = 3'd2,
        REG_PLAIN = 3'd3,
        REG_STAT  = 3'd4
    } reg_id_e;

    typedef struct packed {
        reg_id_e   id;
        alias_op_e op;
        logic [3:0] pidx;
    } dec_t;

endpackage

// File: rtl/clkreg_alias.sv
module clkreg_alias
    import clkreg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] mask,
    input  alias_op_e    op,
    output logic [W-1:0] nxt
);

    logic [W-1:0] raw;

    always_comb begin
        case (op)
            ALIAS_SET: raw = cur | wdata;
            ALIAS_CLR: raw = cur & ~wdata;
            ALIAS_TOG: raw = cur ^ wdata;
            default:   raw = wdata;
        endcase
        nxt = raw & mask;
    end

endmodule

// File: rtl/clkreg_frac_clamp.sv
module clkreg_frac_clamp #(
    parameter int NUM_FIELDS = 4,
    parameter int FIELD_W    = 6,
    parameter int SLOT_W     = 8,
    parameter int MIN_VAL    = 18,
    parameter int MAX_VAL    = 35
) (
    input  logic [NUM_FIELDS*SLOT_W-1:0] raw,
    output logic [NUM_FIELDS*SLOT_W-1:0] clamped,
    output logic                         out_of_range
);

    localparam int TOP_W = SLOT_W - FIELD_W;

    logic [NUM_FIELDS-1:0] below;
    logic [NUM_FIELDS-1:0] above;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        logic [FIELD_W-1:0] fld;
        logic [FIELD_W-1:0] fixed;
        assign fld      = raw[i*SLOT_W +: FIELD_W];
        assign below[i] = fld < FIELD_W'(MIN_VAL);
        assign above[i] = fld > FIELD_W'(MAX_VAL);
        assign fixed    = below[i] ? FIELD_W'(MIN_VAL) :
                          above[i] ? FIELD_W'(MAX_VAL) : fld;
        assign clamped[i*SLOT_W +: SLOT_W] = {raw[i*SLOT_W+FIELD_W +: TOP_W], fixed};
    end

    assign out_of_range = |(below | above);

endmodule

// File: rtl/clkreg_decode.sv
module clkreg_decode
    import clkreg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_PLAIN = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam int IDX_W    = ADDR_W - 4;
    localparam int PLAIN_LO = 2;
    localparam int STAT_IDX = PLAIN_LO + NUM_PLAIN;

    logic [IDX_W-1:0] idx;
    int               idx_i;

    assign idx   = addr[ADDR_W-1:4];
    assign idx_i = int'(idx);

    always_comb begin
        dec.id   = REG_NONE;
        dec.op   = ALIAS_WR;
        dec.pidx = '0;
        if (addr[1:0] == 2'b00) begin
            if (idx_i == 0) begin
                dec.id = REG_FRAC;
                dec.op = alias_op_e'(addr[3:2]);
            end else if (idx_i == 1) begin
                dec.id = REG_BYP;
                dec.op = alias_op_e'(addr[3:2]);
            end else if (addr[3:2] == 2'b00) begin
                if (idx_i >= PLAIN_LO && idx_i < STAT_IDX) begin
                    dec.id   = REG_PLAIN;
                    dec.pidx = 4'(idx_i - PLAIN_LO);
                end else if (idx_i == STAT_IDX) begin
                    dec.id = REG_STAT;
                end
            end
        end
    end

endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank
    import clkreg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int NUM_FIELDS = 4,
    parameter int FIELD_W    = 6,
    parameter int FRAC_MIN   = 18,
    parameter int FRAC_MAX   = 35,
    parameter int BYP_LSB    = 4,
    parameter int BYP_W      = 5,
    parameter int NUM_PLAIN  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] frac_cfg,
    output logic [BYP_W-1:0]  bypass_cfg,
    output logic              err_flag
);

    localparam int SLOT_W = DATA_W / NUM_FIELDS;

    function automatic logic [DATA_W-1:0] frac_pattern(input logic with_min);
        logic [DATA_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            v[i*SLOT_W + SLOT_W - 1] = 1'b1;
            if (with_min) v[i*SLOT_W +: FIELD_W] = FIELD_W'(FRAC_MIN);
            else          v[i*SLOT_W +: FIELD_W] = '1;
        end
        return v;
    endfunction

    localparam logic [DATA_W-1:0] FRAC_MASK = frac_pattern(1'b0);
    localparam logic [DATA_W-1:0] FRAC_RST  = frac_pattern(1'b1);
    localparam logic [DATA_W-1:0] BYP_MASK  = DATA_W'(((1 << BYP_W) - 1) << BYP_LSB);

    typedef struct packed {
        logic [DATA_W-1:0]                frac;
        logic [DATA_W-1:0]                byp;
        logic [NUM_PLAIN-1:0][DATA_W-1:0] plain;
        logic                             err;
        logic [DATA_W-1:0]                rdata;
        logic                             rvalid;
    } state_t;

    state_t s_d, s_q;

    dec_t              wr_dec;
    dec_t              rd_dec;
    logic [DATA_W-1:0] frac_raw;
    logic [DATA_W-1:0] frac_fix;
    logic              frac_bad;
    logic [DATA_W-1:0] byp_next;

    clkreg_decode #(.ADDR_W(ADDR_W), .NUM_PLAIN(NUM_PLAIN)) u_wr_dec (
        .addr (wr_addr),
        .dec  (wr_dec)
    );

    clkreg_decode #(.ADDR_W(ADDR_W), .NUM_PLAIN(NUM_PLAIN)) u_rd_dec (
        .addr (rd_addr),
        .dec  (rd_dec)
    );

    clkreg_alias #(.W(DATA_W)) u_frac_alias (
        .cur   (s_q.frac),
        .wdata (wr_data),
        .mask  (FRAC_MASK),
        .op    (wr_dec.op),
        .nxt   (frac_raw)
    );

    clkreg_frac_clamp #(
        .NUM_FIELDS (NUM_FIELDS),
        .FIELD_W    (FIELD_W),
        .SLOT_W     (SLOT_W),
        .MIN_VAL    (FRAC_MIN),
        .MAX_VAL    (FRAC_MAX)
    ) u_clamp (
        .raw          (frac_raw),
        .clamped      (frac_fix),
        .out_of_range (frac_bad)
    );

    clkreg_alias #(.W(DATA_W)) u_byp_alias (
        .cur   (s_q.byp),
        .wdata (wr_data),
        .mask  (BYP_MASK),
        .op    (wr_dec.op),
        .nxt   (byp_next)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = rd_en;
        s_d.rdata  = '0;

        // Read path sees the current state only
        if (rd_en) begin
            case (rd_dec.id)
                REG_FRAC:  s_d.rdata = s_q.frac;
                REG_BYP:   s_d.rdata = s_q.byp;
                REG_PLAIN: s_d.rdata = s_q.plain[rd_dec.pidx];
                REG_STAT:  s_d.rdata = DATA_W'(s_q.err);
                default:   s_d.rdata = '0;
            endcase
        end

        if (wr_en) begin
            case (wr_dec.id)
                REG_FRAC: begin
                    s_d.frac = frac_fix;
                    if (frac_bad) s_d.err = 1'b1;
                end
                REG_BYP:   s_d.byp = byp_next;
                REG_PLAIN: s_d.plain[wr_dec.pidx] = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.frac   <= FRAC_RST;
            s_q.byp    <= BYP_MASK;
            s_q.plain  <= '0;
            s_q.err    <= 1'b0;
            s_q.rdata  <= '0;
            s_q.rvalid <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data    = s_q.rdata;
    assign rd_valid   = s_q.rvalid;
    assign frac_cfg   = s_q.frac;
    assign bypass_cfg = s_q.byp[BYP_LSB +: BYP_W];
    assign err_flag   = s_q.err;

endmodule

// File: rtl/clkreg_bank_chk.sv
module clkreg_bank_chk #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int NUM_FIELDS = 4,
    parameter int FIELD_W    = 6,
    parameter int FRAC_MIN   = 18,
    parameter int FRAC_MAX   = 35,
    parameter int BYP_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] frac_cfg,
    input logic [BYP_W-1:0]  bypass_cfg,
    input logic              err_flag
);

    localparam int SLOT_W = DATA_W / NUM_FIELDS;

    function automatic logic fields_legal(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (int'(v[i*SLOT_W +: FIELD_W]) < FRAC_MIN) ok = 1'b0;
            if (int'(v[i*SLOT_W +: FIELD_W]) > FRAC_MAX) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic spare_clear(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            for (int b = FIELD_W; b < SLOT_W - 1; b++) begin
                if (v[i*SLOT_W + b]) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    p_rd_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_rd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> ($past(wr_en) && ($past(wr_addr[ADDR_W-1:4]) == '0)));

    p_field_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fields_legal(frac_cfg));

    p_spare_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        spare_clear(frac_cfg));

    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(frac_cfg) && $stable(bypass_cfg)));

    p_misaligned_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr[1:0] != 2'b00)) |=> (rd_data == '0));

    logic unused_ok;
    assign unused_ok = ^wr_data;

endmodule

bind clkreg_bank clkreg_bank_chk u_chk (.*);

// File: tb/clkreg_bank_bench.sv
module clkreg_bank_bench;

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [7:0]  rd_addr;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [31:0] frac_cfg;
    logic [4:0]  bypass_cfg;
    logic        err_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    clkreg_bank u_clkreg_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .frac_cfg   (frac_cfg),
        .bypass_cfg (bypass_cfg),
        .err_flag   (err_flag)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever read data comes back
    always @(negedge clk) begin
        if (rst_n && !done && rd_valid) begin
            if (sb_q.size() == 0) begin
                check("R6 unexpected read data", 32'h1, 32'h0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic idle();
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        rd_en   = 1'b1;
        rd_addr = a;
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic do_both(input logic [7:0] wa, input logic [31:0] d,
                           input logic [7:0] ra, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        wr_en   = 1'b1;
        wr_addr = wa;
        wr_data = d;
        rd_en   = 1'b1;
        rd_addr = ra;
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        wr_addr = '0;
        rd_addr = '0;
        wr_data = '0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        settle();

        // R1 reset state
        check("R1 frac_cfg at reset", frac_cfg, 32'h92929292);
        check("R1 bypass_cfg at reset", {27'd0, bypass_cfg}, 32'h1F);
        check("R1 err_flag at reset", {31'd0, err_flag}, 32'h0);
        check("R6 rd_valid idle", {31'd0, rd_valid}, 32'h0);
        do_read(8'h00, 32'h92929292, "R1 frac reset read");
        do_read(8'h10, 32'h000001F0, "R1 bypass reset read");
        do_read(8'h20, 32'h0, "R1 plain reset read");
        do_read(8'h70, 32'h0, "R1 status reset read");

        // R2 plain write to aliased register, R13 outputs
        do_write(8'h00, 32'h23141A12);
        settle();
        check("R13 frac_cfg after write", frac_cfg, 32'h23141A12);
        do_read(8'h00, 32'h23141A12, "R2 frac base write");
        do_read(8'h04, 32'h23141A12, "R6 read at set alias");
        do_read(8'h0C, 32'h23141A12, "R6 read at toggle alias");

        // R3 set, R4 clear, R5 toggle on the fractional word
        do_write(8'h04, 32'h80000080);
        do_read(8'h00, 32'hA3141A92, "R3 frac set alias");
        do_write(8'h08, 32'h80000000);
        do_read(8'h08, 32'h23141A92, "R4 frac clear alias");
        do_write(8'h0C, 32'h00008080);
        settle();
        check("R5 frac_cfg after toggle", frac_cfg, 32'h23149A12);
        check("R9 no error for legal writes", {31'd0, err_flag}, 32'h0);
        do_read(8'h70, 32'h0, "R9 status still clear");

        // R12 reserved bits of the fractional word
        do_write(8'h00, 32'h63545A52);
        do_read(8'h00, 32'h23141A12, "R12 frac spare bits");

        // R8 clamp both directions, R9 error set
        do_write(8'h00, 32'h00010024);
        settle();
        check("R8 clamp low and high", frac_cfg, 32'h12121223);
        check("R9 err_flag after clamp", {31'd0, err_flag}, 32'h1);
        do_read(8'h70, 32'h1, "R9 status bit 0");
        do_write(8'h04, 32'h00000030);
        do_read(8'h00, 32'h12121223, "R8 clamp after set alias");

        // R9 / R10 status not writable
        do_write(8'h70, 32'h0);
        do_read(8'h70, 32'h1, "R9 sticky after status write");

        // Bypass word, R12 mask, R3/R4/R5, R13
        do_write(8'h10, 32'hFFFFFFFF);
        do_read(8'h10, 32'h000001F0, "R12 bypass spare bits");
        do_write(8'h18, 32'h000000A0);
        settle();
        check("R4 bypass_cfg after clear", {27'd0, bypass_cfg}, 32'h15);
        do_write(8'h14, 32'h00000020);
        do_read(8'h1C, 32'h00000170, "R3 bypass set alias");
        do_write(8'h1C, 32'h00000110);
        settle();
        check("R5 bypass_cfg after toggle", {27'd0, bypass_cfg}, 32'h06);

        // R7 plain words
        do_write(8'h20, 32'hDEADBEEF);
        do_write(8'h30, 32'h12345678);
        do_write(8'h60, 32'hCAFEF00D);
        do_write(8'h24, 32'hFFFFFFFF);
        do_write(8'h28, 32'hFFFFFFFF);
        do_write(8'h3C, 32'hFFFFFFFF);
        do_read(8'h20, 32'hDEADBEEF, "R7 plain word 0x20");
        do_read(8'h30, 32'h12345678, "R7 plain word 0x30");
        do_read(8'h60, 32'hCAFEF00D, "R7 plain word 0x60");
        do_read(8'h40, 32'h0, "R7 unwritten plain word");
        do_read(8'h24, 32'h0, "R7 plain alias reads zero");
        do_read(8'h3C, 32'h0, "R7 plain alias reads zero");

        // R10 unmapped addresses
        do_write(8'h80, 32'h00001234);
        do_write(8'h02, 32'h0);
        do_write(8'h11, 32'h0);
        settle();
        check("R10 frac unchanged by misaligned write", frac_cfg, 32'h12121223);
        check("R10 bypass unchanged by misaligned write", {27'd0, bypass_cfg}, 32'h06);
        do_read(8'h80, 32'h0, "R10 read above map");
        do_read(8'h01, 32'h0, "R10 misaligned read");
        do_read(8'h74, 32'h0, "R10 status offset read");

        // R11 same-cycle read and write
        do_both(8'h20, 32'h11111111, 8'h20, 32'hDEADBEEF, "R11 read sees old plain value");
        do_read(8'h20, 32'h11111111, "R11 new plain value next cycle");
        do_both(8'h08, 32'h00000080, 8'h00, 32'h12121223, "R11 read sees old frac value");
        do_read(8'h00, 32'h12121223, "R11 frac after clear of clear gate");

        repeat (3) @(posedge clk);
        settle();
        check("R6 scoreboard drained", sb_q.size(), 32'h0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule